// File: doc/BRIEF.md
# Two-Wire Conversion Command and Readout Engine

This block is the serial slave front end of a small multi-channel data acquisition unit. It watches an oversampled two-wire bus (clock line and data line, both sampled by the system clock). It decodes a one-byte command and acknowledges a valid conversion-read command by pulling the data line low. It then asks an external converter for a 10-bit result on the selected channel and shifts that result back to the host as two bytes, most significant bit first.

The host can keep a session going. If it acknowledges the second byte instead of ending with a STOP, a fresh conversion is started and another two-byte frame follows. The new conversion uses the same channel, or the next channel when the command asked for auto-increment. The block also raises a sample strobe while the analog front end should be tracking its input. Limit-register programming and monitor mode are handled elsewhere. Commands that select them are not answered here.

Top module: `das_cmd_engine`

## Requirements
- R1: While reset is held, and in the cycle after reset is released, `sda_pd_o`, `conv_req_o` and `sample_o` are all low.
- R2: After a START, the command byte is received MSB first: bits 7:4 identifier, bit 3 function (0 = conversion), bits 2:1 channel, bit 0 read (1 = read). A command with identifier equal to `DEV_ID`, function 0 and read 1 is accepted. The block pulls SDA low for the ninth clock and raises exactly one conversion request.
- R3: A command that does not match R2 leaves SDA released on the ninth clock and raises no conversion request. This covers a wrong identifier, function bit 1, or read bit 0. SDA then stays released until the next START.
- R4: Each result frame is two bytes sent MSB first. Byte one is 0000, then the 2-bit channel converted, then result bits 9 and 8. Byte two is result bits 7 down to 0. The pull-down only changes while SCL is low.
- R5: `sample_o` rises together with a new conversion request. For the command this is on the SCL fall that opens the ACK slot. For a repeated conversion it is on the SCL rise that samples the host ACK. `sample_o` is high through the following SCL high phase and falls on the SCL rise of the first data bit of the frame.
- R6: `conv_req_o` stays high until `conv_done_i` is seen. The result on `conv_data_i` in that cycle is the value that is serialized.
- R7: A host ACK (SDA low) after byte two starts a new conversion on the same channel and a new frame.
- R8: Channel field 11 selects auto-increment. Conversions run on channels 0, 1, 2, 0, ... and wrap after channel `NUM_CH`-1.
- R9: A host NACK (SDA high) after a byte starts no conversion and leaves SDA released until the next START.
- R10: A STOP at any point clears `conv_req_o`, `sample_o` and `sda_pd_o` on the following cycle and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| conv_done_i | input | 1 | Converter finished, result valid this cycle |
| conv_data_i | input | 10 | Converter result |
| sda_pd_o | output | 1 | Pull-down enable for the data line (1 = drive low) |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_ch_o | output | 2 | Channel to convert |
| sample_o | output | 1 | Analog sampling window |

## Verification
On every cycle, the assertions check four things. The data-line drive never changes while SCL is high. A request only drops after a done or a STOP. A STOP leaves all three outputs quiet. The sample strobe never rises without a new request. The bench scenarios are needed for the rest: the exact ACK and frame bit contents, the channel sequence under auto-increment, and the refusal of mismatched or non-conversion commands. They also cover the end of a session on a host NACK and the closing of the sample window on the first data bit.

// File: rtl/das_pkg.sv
package das_pkg;
  localparam int CH_W       = 2;
  localparam int RES_W      = 10;
  localparam int LEAD_ZEROS = 4;
  localparam int FRAME_W    = LEAD_ZEROS + CH_W + RES_W;
  localparam logic [3:0] BYTE_BITS = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DACK,
    ST_SEND,
    ST_HACK,
    ST_WAIT
  } das_state_t;
endpackage

// File: rtl/das_line_monitor.sv
module das_line_monitor #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[TOP];
      sda_p  <= sda_sh[TOP];
    end
  end

  assign scl_s      = scl_sh[TOP];
  assign sda_s      = sda_sh[TOP];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/das_cmd_decode.sv
module das_cmd_decode #(
  parameter logic [3:0] DEV_ID = 4'b1001
) (
  input  logic [7:0] cmd_i,
  output logic       accept_o,
  output logic       auto_o,
  output logic [1:0] ch_o
);
  logic id_hit, is_conv, is_read;

  assign id_hit   = (cmd_i[7:4] == DEV_ID);
  assign is_conv  = ~cmd_i[3];
  assign is_read  = cmd_i[0];
  assign accept_o = id_hit & is_conv & is_read;
  assign auto_o   = (cmd_i[2:1] == 2'b11);
  assign ch_o     = cmd_i[2:1];
endmodule

// File: rtl/das_chan_step.sv
module das_chan_step #(
  parameter int NUM_CH = 3
) (
  input  logic [1:0] cur_i,
  output logic [1:0] nxt_o
);
  localparam logic [1:0] LAST = 2'(NUM_CH - 1);

  assign nxt_o = (cur_i >= LAST) ? 2'd0 : cur_i + 2'd1;
endmodule

// File: rtl/das_cmd_engine.sv
module das_cmd_engine
  import das_pkg::*;
#(
  parameter int         NUM_CH      = 3,
  parameter logic [3:0] DEV_ID      = 4'b1001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             sda_pd_o,
  output logic             conv_req_o,
  output logic [CH_W-1:0]  conv_ch_o,
  output logic             sample_o
);
  logic sda_q, scl_rise, scl_fall, start_ev, stop_ev;
  logic dec_accept, dec_auto;
  logic [1:0] dec_ch, ch_step;

  das_state_t state_q, state_n;
  logic [3:0] cnt_q, cnt_n;
  logic       hi_q, hi_n;
  logic [7:0] shreg_q, shreg_n;
  logic [CH_W-1:0] ch_q, ch_n;
  logic       auto_q, auto_n;
  logic [RES_W-1:0] res_q, res_n;
  logic       req_q, req_n;
  logic       samp_q, samp_n;
  logic       pd_q, pd_n;
  logic       hack_q, hack_n;
  logic [FRAME_W-1:0] frame_w;

  das_line_monitor #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_q), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  das_cmd_decode #(.DEV_ID(DEV_ID)) u_dec (
    .cmd_i(shreg_q), .accept_o(dec_accept), .auto_o(dec_auto), .ch_o(dec_ch)
  );

  das_chan_step #(.NUM_CH(NUM_CH)) u_step (
    .cur_i(ch_q), .nxt_o(ch_step)
  );

  assign frame_w = {{LEAD_ZEROS{1'b0}}, ch_q, res_q};

  // bit 15 - {hi,pos} of the frame, i.e. MSB first within each byte
  function automatic logic pick_bit(input logic [FRAME_W-1:0] f,
                                    input logic hi, input logic [2:0] pos);
    pick_bit = f[{~hi, ~pos}];
  endfunction

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    hi_n    = hi_q;
    shreg_n = shreg_q;
    ch_n    = ch_q;
    auto_n  = auto_q;
    res_n   = res_q;
    req_n   = req_q;
    samp_n  = samp_q;
    pd_n    = pd_q;
    hack_n  = hack_q;

    if (req_q && conv_done_i) begin
      req_n = 1'b0;
      res_n = conv_data_i;
    end

    if (stop_ev) begin
      state_n = ST_IDLE;
      req_n   = 1'b0;
      samp_n  = 1'b0;
      pd_n    = 1'b0;
    end else if (start_ev) begin
      state_n = ST_CMD;
      cnt_n   = '0;
      samp_n  = 1'b0;
      pd_n    = 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: begin
          if (scl_rise) begin
            shreg_n = {shreg_q[6:0], sda_q};
            if (cnt_q != BYTE_BITS) cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BYTE_BITS) begin
            if (dec_accept) begin
              state_n = ST_DACK;
              pd_n    = 1'b1;
              samp_n  = 1'b1;
              req_n   = 1'b1;
              ch_n    = dec_auto ? '0 : dec_ch;
              auto_n  = dec_auto;
            end else begin
              state_n = ST_WAIT;
            end
          end
        end
        ST_DACK: begin
          if (scl_fall) begin
            state_n = ST_SEND;
            cnt_n   = '0;
            hi_n    = 1'b0;
            pd_n    = ~pick_bit(frame_w, 1'b0, 3'd0);
          end
        end
        ST_SEND: begin
          if (scl_rise) begin
            samp_n = 1'b0;
            cnt_n  = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == BYTE_BITS) begin
              pd_n    = 1'b0;
              state_n = ST_HACK;
            end else begin
              pd_n = ~pick_bit(frame_w, hi_q, cnt_q[2:0]);
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            hack_n = ~sda_q;
            if (hi_q && !sda_q) begin
              samp_n = 1'b1;
              req_n  = 1'b1;
              if (auto_q) ch_n = ch_step;
            end
          end else if (scl_fall) begin
            if (hack_q) begin
              state_n = ST_SEND;
              cnt_n   = '0;
              hi_n    = ~hi_q;
              pd_n    = ~pick_bit(frame_w, ~hi_q, 3'd0);
            end else begin
              state_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      shreg_q <= '0;
      ch_q    <= '0;
      auto_q  <= 1'b0;
      res_q   <= '0;
      req_q   <= 1'b0;
      samp_q  <= 1'b0;
      pd_q    <= 1'b0;
      hack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      hi_q    <= hi_n;
      shreg_q <= shreg_n;
      ch_q    <= ch_n;
      auto_q  <= auto_n;
      res_q   <= res_n;
      req_q   <= req_n;
      samp_q  <= samp_n;
      pd_q    <= pd_n;
      hack_q  <= hack_n;
    end
  end

  assign sda_pd_o   = pd_q;
  assign conv_req_o = req_q;
  assign conv_ch_o  = ch_q;
  assign sample_o   = samp_q;
endmodule

// File: rtl/das_cmd_engine_chk.sv
module das_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pd_o,
  input logic conv_req_o,
  input logic conv_done_i,
  input logic sample_o,
  input logic stop_ev
);
  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sda_pd_o && !conv_req_o && !sample_o)); // R1

  AST_PD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd_o) |-> !scl_i); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_req_o) |-> ($past(conv_done_i) || $past(stop_ev))); // R6

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!conv_req_o && !sample_o && !sda_pd_o)); // R10

  AST_SAMPLE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_o) |-> $rose(conv_req_o)); // R5
endmodule

bind das_cmd_engine das_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pd_o(sda_pd_o),
  .conv_req_o(conv_req_o), .conv_done_i(conv_done_i),
  .sample_o(sample_o), .stop_ev(stop_ev)
);

// File: tb/sim_das_cmd_engine.sv
module sim_das_cmd_engine;
  localparam logic [3:0] ID = 4'b1001;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, host_sda;
  logic conv_done;
  logic [9:0] conv_data;
  logic sda_pd_o, conv_req_o, sample_o;
  logic [1:0] conv_ch_o;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;

  logic busy;
  int lat;
  logic [9:0] mdata;
  logic [1:0] mch;
  int nreq;
  bit hold_done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = host_sda & ~sda_pd_o;

  das_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .sda_pd_o(sda_pd_o), .conv_req_o(conv_req_o),
    .conv_ch_o(conv_ch_o), .sample_o(sample_o)
  );

  // converter model
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) begin
      busy <= 1'b0; nreq <= 0; lat <= 0; conv_data <= '0;
    end else if (conv_req_o && !busy) begin
      busy <= 1'b1;
      lat <= 2 + int'($urandom % 5);
      mch <= conv_ch_o;
      mdata <= 10'($urandom);
      nreq <= nreq + 1;
    end else if (busy && conv_req_o && !conv_done) begin
      if (lat == 0) begin
        if (!hold_done) begin conv_done <= 1'b1; conv_data <= mdata; end
      end else lat <= lat - 1;
    end else if (busy && !conv_req_o) begin
      busy <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic clock_bit(input logic b, output logic r, output logic s);
    repeat (2) @(negedge clk);
    host_sda = b;
    repeat (HALF-2) @(negedge clk);
    scl = 1'b1;
    repeat (HALF-2) @(negedge clk);
    r = sda_line;
    s = sample_o;
    repeat (2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    repeat (HALF) @(negedge clk); host_sda = 1'b1;
    repeat (HALF) @(negedge clk); scl = 1'b1;
    repeat (HALF) @(negedge clk); host_sda = 1'b0;
    repeat (HALF) @(negedge clk); scl = 1'b0;
  endtask

  task automatic bus_stop();
    repeat (2) @(negedge clk); host_sda = 1'b0;
    repeat (HALF) @(negedge clk); scl = 1'b1;
    repeat (HALF) @(negedge clk); host_sda = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] cmd, output int r0);
    logic r, s;
    for (int i = 0; i < 8; i++) begin
      if (i == 7) r0 = nreq;
      clock_bit(cmd[7-i], r, s);
    end
  endtask

  function automatic logic [1:0] next_ch(input logic [1:0] c);
    return (c == 2'd2) ? 2'd0 : c + 2'd1;
  endfunction

  task automatic read_byte(input bit first, output logic [7:0] v);
    logic r, s;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, r, s);
      v[7-i] = r;
      if (first && i == 0) chk(s == 1'b0, "R5 window closed on first data bit", s, 0);
    end
  endtask

  task automatic do_txn(input logic [1:0] ch, input int frames);
    logic [7:0] cmd, b1, b2;
    logic r, s;
    int r0;
    bit auto_m;
    logic [1:0] ech;
    string tag;
    cmd = {ID, 1'b0, ch, 1'b1};
    auto_m = (ch == 2'b11);
    ech = auto_m ? 2'd0 : ch;
    tag = auto_m ? "R8 channel" : "R7 channel";
    bus_start();
    send_cmd(cmd, r0);
    clock_bit(1'b1, r, s);
    chk(r == 1'b0, "R2 ack low", r, 0);
    chk(s == 1'b1, "R5 sample during ack", s, 1);
    chk(nreq == r0 + 1, "R2 one request", nreq - r0, 1);
    for (int f = 0; f < frames; f++) begin
      read_byte(1'b1, b1);
      clock_bit(1'b0, r, s);
      read_byte(1'b0, b2);
      chk(b1 == {4'b0000, ech, mdata[9:8]}, "R4 byte one", b1, {4'b0000, ech, mdata[9:8]});
      chk(b2 == mdata[7:0], "R6 R4 byte two", b2, mdata[7:0]);
      chk(mch == ech, tag, mch, ech);
      if (f < frames - 1) begin
        r0 = nreq;
        clock_bit(1'b0, r, s);
        chk(s == 1'b1, "R5 sample on host ack", s, 1);
        chk(nreq == r0 + 1, "R7 repeat request", nreq - r0, 1);
        if (auto_m) ech = next_ch(ech);
      end else begin
        clock_bit(1'b1, r, s);
        r0 = nreq;
        clock_bit(1'b1, r, s);
        chk(r == 1'b1, "R9 released after nack", r, 1);
        chk(nreq == r0, "R9 no request after nack", nreq - r0, 0);
      end
    end
    bus_stop();
    repeat (4) @(negedge clk);
    chk(!sda_pd_o && !conv_req_o && !sample_o, "R10 idle after stop",
        {sda_pd_o, conv_req_o, sample_o}, 0);
  endtask

  task automatic bad_cmd(input logic [7:0] cmd, input string tag);
    logic r, s;
    logic [7:0] v;
    int r0;
    bus_start();
    send_cmd(cmd, r0);
    clock_bit(1'b1, r, s);
    chk(r == 1'b1, tag, r, 1);
    chk(nreq == r0 && s == 1'b0, "R3 no request", nreq - r0, 0);
    read_byte(1'b0, v);
    chk(v == 8'hFF, "R3 line stays released", v, 8'hFF);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic r, s;
    int r0;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; scl = 1'b1; host_sda = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_pd_o == 1'b0, "R1 pull-down in reset", sda_pd_o, 0);
    chk(conv_req_o == 1'b0, "R1 request in reset", conv_req_o, 0);
    chk(sample_o == 1'b0, "R1 sample in reset", sample_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    do_txn(2'd1, 2);
    do_txn(2'd0, 1);
    do_txn(2'b11, 4);
    bad_cmd({4'b1011, 1'b0, 2'd1, 1'b1}, "R3 no ack for wrong id");
    bad_cmd({ID, 1'b1, 2'd0, 1'b1}, "R3 no ack for limit select");
    bad_cmd({ID, 1'b0, 2'd2, 1'b0}, "R3 no ack for monitor");

    // request held while converter is busy, cleared by STOP
    hold_done = 1'b1;
    bus_start();
    send_cmd({ID, 1'b0, 2'd2, 1'b1}, r0);
    clock_bit(1'b1, r, s);
    read_byte(1'b1, v);
    chk(conv_req_o == 1'b1, "R6 request held until done", conv_req_o, 1);
    clock_bit(1'b1, r, s);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(conv_req_o == 1'b0, "R10 stop drops request", conv_req_o, 0);
    hold_done = 1'b0;
    repeat (10) @(negedge clk);

    for (int k = 0; k < 25; k++) begin
      do_txn(2'($urandom % 4), 1 + int'($urandom % 3));
    end
    finish_run();
  end
endmodule